// File: doc/BRIEF.md
# Serial Packet Transmitter with Transition Line Code

The block turns a stream of bytes into one serial data packet on a single wire. The first byte accepted from an idle transmitter is the packet type. The bytes after it, up to the one marked last, are the payload. On the wire the packet is a fixed synchronisation byte, then the type, then the payload, then a 16-bit CRC computed over the payload alone.

Bits are released one per pulse of a bit-rate strobe. They are written with a transition code: a zero flips the line and a one leaves it alone, so zeros make a steady pulse train for clock recovery. The line rests high. After the final CRC bit, the next strobe puts the line back to rest and raises a one-cycle completion pulse.

A payload longer than the limit is cut at the limit. The extra bytes are still accepted from upstream, so the source can drain, but they are discarded and each one raises an error pulse.

Top module: `serial_pkt_tx`

## Requirements
- R1: After reset the line is high, `in_ready` is high, and `done` and `err` are low. While no packet is in flight the line stays high.
- R2: A packet is sent as: sync byte 0x80, then the type byte (the first byte accepted while idle), then the payload bytes in arrival order, then the 16-bit CRC. `in_last` marks the final input byte. `in_last` on the type byte means an empty payload.
- R3: Every field is sent least significant bit first. The sync byte therefore appears as seven 0 bits followed by one 1 bit.
- R4: Bit coding: a 0 bit toggles the line, and a 1 bit keeps the line at its current level.
- R5: The CRC is a reflected CRC-16 with generator x^16+x^15+x^2+1. The register is preset to 0xFFFF and is updated for each payload bit, LSB first: shift right, and XOR 0xA001 when the old bit 0 XOR the data bit is 1. Only payload bits are covered. The ones' complement of the final register is sent LSB first. An empty payload therefore sends sixteen 0 bits.
- R6: The line changes only at a clock edge where `bit_en` is high. Each such edge during a packet emits exactly one bit.
- R7: A payload byte is accepted only when the shifter is empty. While the bits of the type byte or of a payload byte are being shifted out, `in_ready` is low.
- R8: At most 64 payload bytes are sent. Any further bytes up to `in_last` are accepted and discarded, each with a one-cycle `err` pulse. The CRC covers only the 64 bytes that were sent. No new packet starts until the discarded bytes are drained.
- R9: The strobe after the last CRC bit returns the line high and raises `done` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate strobe; one line bit per high cycle |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte (type first, then payload) |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ready | output | 1 | Byte is taken when high together with `in_valid` |
| line | output | 1 | Transition-coded serial line, high at rest |
| done | output | 1 | One-cycle pulse when the line returns to rest |
| err | output | 1 | One-cycle pulse per discarded over-length byte |

## Verification
The bench goes after several corner cases, and each has a visible failure mode:
- **Empty payload.** A wrong CRC preset or a missing complement shows up here as a non-zero CRC field.
- **All-zero payload.** A design with the code polarity inverted produces a flat line where a pulse train is expected.
- **Exactly 64 bytes, with no error.** A design with an off-by-one payload limit either raises `err` or truncates one byte early.
- **Three bytes over the limit.** A design that does not drain stalls the source. A design that keeps the extra bytes sends a longer packet, and a design that folds them into the CRC sends a wrong CRC.
- **Ready timing and the idle gap.** Checking `in_ready` right after every handshake catches a design that overwrites the shifter before it is empty. Checking for line movement between strobes catches bits emitted at the wrong rate.

// File: rtl/serial_pkt_tx.sv
module serial_pkt_tx #(
  parameter int          MAXP      = 64,
  parameter logic [7:0]  SYNC_BYTE = 8'h80,
  parameter logic [15:0] CRC_POLY  = 16'hA001,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       line,
  output logic       done,
  output logic       err
);
  localparam int CW = $clog2(MAXP + 1);

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_TYPE, S_PAY, S_CRC, S_EOP} st_t;

  st_t           st;
  logic [7:0]    sh, tyb;
  logic [3:0]    bcnt;
  logic          full, lastq, drain;
  logic [15:0]   crc;
  logic [CW-1:0] npay;

  logic        take, shift, txb, fb;
  logic [15:0] crc_nxt;

  assign in_ready = drain || (st == S_IDLE) || (st == S_PAY && !full);
  assign take     = in_valid && in_ready;
  assign shift    = bit_en && full &&
                    (st == S_SYNC || st == S_TYPE || st == S_PAY || st == S_CRC);
  assign txb      = (st == S_CRC) ? ~crc[0] : sh[0];
  assign fb       = crc[0] ^ sh[0];
  assign crc_nxt  = {1'b0, crc[15:1]} ^ (fb ? CRC_POLY : 16'h0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sh    <= '0;
      tyb   <= '0;
      bcnt  <= '0;
      full  <= 1'b0;
      lastq <= 1'b0;
      drain <= 1'b0;
      crc   <= CRC_INIT;
      npay  <= '0;
      line  <= 1'b1;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;

      if (drain && take) begin
        err <= 1'b1;
        if (in_last) drain <= 1'b0;
      end else if (take && st == S_IDLE) begin
        tyb   <= in_data;
        sh    <= SYNC_BYTE;
        full  <= 1'b1;
        bcnt  <= '0;
        lastq <= in_last;
        npay  <= '0;
        crc   <= CRC_INIT;
        st    <= S_SYNC;
      end else if (take && st == S_PAY) begin
        sh    <= in_data;
        full  <= 1'b1;
        bcnt  <= '0;
        npay  <= npay + 1'b1;
        lastq <= in_last;
        if (!in_last && npay == CW'(MAXP - 1)) begin
          drain <= 1'b1;
          lastq <= 1'b1;
        end
      end

      if (shift) begin
        line <= txb ? line : ~line;
        bcnt <= bcnt + 4'd1;
        sh   <= sh >> 1;
        case (st)
          S_SYNC: if (bcnt == 4'd7) begin
            sh   <= tyb;
            bcnt <= '0;
            st   <= S_TYPE;
          end
          S_TYPE: if (bcnt == 4'd7) begin
            bcnt <= '0;
            if (lastq) st <= S_CRC;
            else begin
              st   <= S_PAY;
              full <= 1'b0;
            end
          end
          S_PAY: begin
            crc <= crc_nxt;
            if (bcnt == 4'd7) begin
              bcnt <= '0;
              if (lastq) st <= S_CRC;
              else full <= 1'b0;
            end
          end
          S_CRC: begin
            crc <= crc >> 1;
            if (bcnt == 4'd15) st <= S_EOP;
          end
          default: ;
        endcase
      end

      if (st == S_EOP && bit_en) begin
        line <= 1'b1;
        done <= 1'b1;
        full <= 1'b0;
        st   <= S_IDLE;
      end
    end
  end

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> line);
  assert_line_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    npay <= CW'(MAXP));
  assert_err_at_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (npay == CW'(MAXP)));
  assert_done_at_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> line);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/serial_pkt_tx_tb.sv
module serial_pkt_tx_tb;
  localparam int NB = 544;

  logic clk = 0, rst_n = 0, bit_en = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, line, done, err;

  serial_pkt_tx u_dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .line(line),
    .done(done), .err(err));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [NB-1:0] exp_q[$];
  int len_q[$];
  int exp_err = 0, err_seen = 0;
  logic [7:0] pay [0:127];

  task automatic chk(input bit ok, input string tag, input logic [NB-1:0] act,
                     input logic [NB-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  logic [NB-1:0] eb;
  int ep;
  logic [15:0] ecrc;

  task automatic put_bits(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin eb[ep] = b[i]; ep++; end
  endtask

  task automatic crc_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic f;
      f = ecrc[0] ^ b[i];
      ecrc = {1'b0, ecrc[15:1]} ^ (f ? 16'hA001 : 16'h0000);
    end
  endtask

  task automatic put_byte(input logic [7:0] d, input bit last, input int k);
    in_valid = 1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0;
    if (k < 64 || (k == 64 && last))
      chk(in_ready == 0, "R7 ready low while shifter full", NB'(in_ready), 0);
  endtask

  task automatic send_pkt(input logic [7:0] typ, input int n, input int mode);
    int sent;
    sent = (n > 64) ? 64 : n;
    for (int i = 0; i < n; i++)
      pay[i] = (mode == 0) ? 8'h00 : (mode == 1) ? 8'hFF : 8'(i * 29 + 7 + typ);
    eb = '0; ep = 0; ecrc = 16'hFFFF;
    put_bits(8'h80);
    put_bits(typ);
    for (int i = 0; i < sent; i++) begin put_bits(pay[i]); crc_byte(pay[i]); end
    ecrc = ~ecrc;
    put_bits(ecrc[7:0]);
    put_bits(ecrc[15:8]);
    exp_q.push_back(eb);
    len_q.push_back(ep);
    if (n > 64) exp_err += n - 64;
    put_byte(typ, n == 0, 0);
    for (int i = 0; i < n; i++) put_byte(pay[i], i == n - 1, i + 1);
  endtask

  // bit strobe: one cycle in four
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      bit_en = (c % 4 == 0);
    end
  end

  // monitor / scoreboard
  logic ben_q = 0;
  always @(posedge clk) ben_q <= bit_en;

  bit in_pkt = 0, done_prev = 0;
  logic prevl, line_prev_neg = 1;
  logic [NB-1:0] got;
  int nb = 0, stab_bad = 0;

  always @(negedge clk) if (rst_n) begin
    if (err) err_seen++;
    if (done_prev) chk(done == 0, "R9 done one cycle", NB'(done), 0);
    done_prev = done;
    if (in_pkt && !ben_q && line !== line_prev_neg) stab_bad++;
    line_prev_neg = line;
    if (ben_q) begin
      if (!in_pkt) begin
        if (line == 0) begin
          in_pkt = 1; got = '0; got[0] = 0; nb = 1; prevl = 0; stab_bad = 0;
        end
      end else if (done) begin
        logic [NB-1:0] e;
        int el;
        in_pkt = 0;
        chk(line == 1, "R9 line at rest with done", NB'(line), 1);
        chk(stab_bad == 0, "R6 line moved without strobe", NB'(stab_bad), 0);
        if (exp_q.size() == 0) chk(0, "R2 unexpected packet", got, 0);
        else begin
          e = exp_q.pop_front();
          el = len_q.pop_front();
          chk(nb == el, "R2 R8 packet bit length", NB'(nb), NB'(el));
          chk(got[15:0] == e[15:0], "R3 sync and type LSB first", NB'(got[15:0]), NB'(e[15:0]));
          chk(got == e, "R4 R5 full decoded stream", got, e);
        end
      end else if (nb < NB) begin
        got[nb] = (line == prevl);
        nb++;
        prevl = line;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(line == 1, "R1 line high after reset", NB'(line), 1);
    chk(in_ready == 1, "R1 ready after reset", NB'(in_ready), 1);
    chk(done == 0 && err == 0, "R1 pulses low after reset", NB'({done, err}), 0);
    rst_n = 1;
    @(negedge clk);
    send_pkt(8'hC3, 0, 2);   // R5 empty payload
    send_pkt(8'h4B, 1, 0);   // R4 zero byte pulse train
    send_pkt(8'hD2, 5, 1);   // all ones
    send_pkt(8'h5A, 64, 2);  // R8 boundary, no error
    send_pkt(8'h69, 67, 2);  // R8 truncated, three discards
    send_pkt(8'hE1, 3, 2);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(err_seen == exp_err, "R8 discard error pulses", NB'(err_seen), NB'(exp_err));
    chk(line == 1 && in_ready == 1, "R1 rest state after traffic", NB'({line, in_ready}), 2'b11);
    finish_run();
  end
endmodule